// File: doc/BRIEF.md
# MDIO Management Master with Selectable Clock Divider

This block is the management side of an Ethernet PHY interface. Software first sets an enable bit and a two-bit divider choice in a small control register. It then writes a 32-bit management frame word. While the port is enabled and idle, that write starts a transaction. The engine sends 32 preamble ones and then the frame word on the serial data line, most significant bit first. The management clock for this serial traffic is derived from the system clock.

For a read operation, the engine releases the data line from the turnaround bits onwards. It shifts in the sixteen bits the PHY returns, and on completion those bits replace the low half of the frame register. An idle flag is low for the whole transaction. Software polls the flag, then reads the frame register to get the result.

The divider choice selects a management clock period of 8, 16, 32 or 64 system clocks. This lets the serial clock stay under the PHY's limit across system clocks below 20 MHz, 40 MHz, 80 MHz, and above 80 MHz.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, idle is high, mdc is low, mdio_oe is low, the frame register reads zero and the port is disabled.
- R2: A frame write while the enable bit is clear starts nothing and leaves the frame register unchanged.
- R3: A frame write accepted at a clock edge loads the frame register and drives idle low from that edge. Idle returns high exactly 64 management clock periods later.
- R4: The management clock period is 8 << div_sel system clocks (div_sel 0..3 gives 8, 16, 32, 64). Each period is low for its first half and high for its second half. mdc is low while idle.
- R5: A transaction sends 32 ones and then the frame word, MSB first. Frame word layout: [31:30] start pattern 01, [29:28] operation (01 write, 10 read), [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data.
- R6: mdio_out changes only at a falling edge of mdc, so it is stable while mdc is high.
- R7: For a read, mdio_oe is low from frame bit 17 to the end of the transaction. For a write, mdio_oe is high for the whole transaction. mdio_oe is low while idle.
- R8: For a read, mdio_in is sampled at each rising mdc edge during frame bits 15..0, first-received bit as MSB. These 16 bits replace frame register bits [15:0] when idle rises, and the other fields keep their written values.
- R9: A frame write while a transaction is in progress is ignored; the frame register and the running transaction are unaffected.
- R10: The divider choice is captured when a transaction starts. A control write during the transaction does not change that transaction's mdc period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_enable | input | 1 | Management port enable value to write |
| ctl_div_sel | input | 2 | Divider choice to write (8 << value) |
| frm_we | input | 1 | Frame register write strobe; starts a transaction when accepted |
| frm_wdata | input | 32 | Frame word to write |
| frm_rdata | output | 32 | Current frame register contents, with read data after a read |
| idle | output | 1 | High when no transaction is in progress |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Serial data from the PHY |
| mdio_out | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_out |

## Verification
The assertions assume that mdio_in and all register strobes are synchronous to the system clock and free of X after reset. They also assume that software only starts frames through the frame strobe. The bench drives every input half a cycle away from the sampling edge. It changes mdio_in only from its PHY model, in step with the expected bit position, so each read bit is settled well before the rising mdc edge that samples it. Control writes arrive both between and during transactions, to exercise the captured divider choice.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/mdio_div.sv
module mdio_div #(
    parameter int SEL_W    = 2,
    parameter int BASE_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise,
    output logic             bit_end
);
    localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t q, d;
    logic [CNT_W:0] ratio, last, half, half_m1;

    always_comb begin
        ratio   = (CNT_W+1)'(BASE_DIV) << sel;
        last    = ratio - 1'b1;
        half    = ratio >> 1;
        half_m1 = half - 1'b1;
        d = q;
        if (!run)
            d.cnt = '0;
        else if (q.cnt == last[CNT_W-1:0])
            d.cnt = '0;
        else
            d.cnt = q.cnt + 1'b1;
        d.mdc   = run && (d.cnt >= half[CNT_W-1:0]);
        rise    = run && (q.cnt == half_m1[CNT_W-1:0]);
        bit_end = run && (q.cnt == last[CNT_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int PRE_W   = 32,
    parameter int DATA_W  = 16,
    parameter int TA_BITS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] word,
    input  logic               rise,
    input  logic               bit_end,
    input  logic               mdio_in,
    output logic               busy,
    output logic               done,
    output logic               is_read,
    output logic               mdio_out,
    output logic               mdio_oe,
    output logic [DATA_W-1:0]  rdata
);
    localparam int TOTAL      = PRE_W + FRAME_W;
    localparam int IDX_W      = $clog2(TOTAL);
    localparam int RELEASE_AT = PRE_W + FRAME_W - DATA_W - TA_BITS;
    localparam int CAPTURE_AT = PRE_W + FRAME_W - DATA_W;
    localparam int OP_HI      = FRAME_W - 3;

    typedef struct packed {
        logic               busy;
        logic               rd;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] sh;
        logic [DATA_W-1:0]  cap;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.rd   = (word[OP_HI -: 2] == OP_READ);
            d.idx  = '0;
            d.sh   = word;
            d.cap  = '0;
        end else if (q.busy) begin
            if (rise && q.rd && (q.idx >= IDX_W'(CAPTURE_AT)))
                d.cap = {q.cap[DATA_W-2:0], mdio_in};
            if (bit_end) begin
                if (q.idx == IDX_W'(TOTAL - 1)) begin
                    d.busy = 1'b0;
                    d.idx  = '0;
                    done   = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                    if (q.idx >= IDX_W'(PRE_W))
                        d.sh = {q.sh[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign is_read  = q.rd;
    assign rdata    = q.cap;
    assign mdio_out = (q.idx < IDX_W'(PRE_W)) ? 1'b1 : q.sh[FRAME_W-1];
    assign mdio_oe  = q.busy && !(q.rd && (q.idx >= IDX_W'(RELEASE_AT)));
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt #(
    parameter int FRAME_W  = 32,
    parameter int PRE_W    = 32,
    parameter int DATA_W   = 16,
    parameter int SEL_W    = 2,
    parameter int BASE_DIV = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic               ctl_enable,
    input  logic [SEL_W-1:0]   ctl_div_sel,
    input  logic               frm_we,
    input  logic [FRAME_W-1:0] frm_wdata,
    output logic [FRAME_W-1:0] frm_rdata,
    output logic               idle,
    output logic               mdc,
    input  logic               mdio_in,
    output logic               mdio_out,
    output logic               mdio_oe
);
    typedef struct packed {
        logic               en;
        logic [SEL_W-1:0]   sel;
        logic [SEL_W-1:0]   run_sel;
        logic [FRAME_W-1:0] frame;
    } top_t;

    top_t st_q, st_d;
    logic eng_busy, eng_done, eng_rd, start, rise, bit_end;
    logic [DATA_W-1:0] eng_rdata;

    assign start = frm_we && st_q.en && !eng_busy;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.en  = ctl_enable;
            st_d.sel = ctl_div_sel;
        end
        if (start) begin
            st_d.frame   = frm_wdata;
            st_d.run_sel = st_q.sel;
        end
        if (eng_done && eng_rd)
            st_d.frame[DATA_W-1:0] = eng_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mdio_div #(.SEL_W(SEL_W), .BASE_DIV(BASE_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .sel(st_q.run_sel),
        .mdc(mdc), .rise(rise), .bit_end(bit_end)
    );

    mdio_engine #(.FRAME_W(FRAME_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .word(frm_wdata),
        .rise(rise), .bit_end(bit_end), .mdio_in(mdio_in),
        .busy(eng_busy), .done(eng_done), .is_read(eng_rd),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rdata(eng_rdata)
    );

    assign frm_rdata = st_q.frame;
    assign idle      = !eng_busy;
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
    parameter int FRAME_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               idle,
    input logic               mdc,
    input logic               mdio_out,
    input logic               mdio_oe,
    input logic               frm_we,
    input logic               en,
    input logic [FRAME_W-1:0] frm_rdata
);
    // R4: the management clock rests low between transactions
    a_r4_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mdc);

    // R7: the data line is never driven while idle
    a_r7_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mdio_oe);

    // R6: data is held steady through the high phase of mdc
    a_r6_out_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_out));

    // R3: an enabled write on an idle port starts a transaction
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && frm_we && en) |=> !idle);

    // R2: a write while disabled leaves the port idle
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && frm_we && !en) |=> idle);

    // R9: the frame register holds still inside a transaction
    a_r9_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle)) |-> $stable(frm_rdata));
endmodule

bind mdio_mgmt mdio_mgmt_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .idle(idle), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .frm_we(frm_we), .en(st_q.en), .frm_rdata(frm_rdata)
);

// File: tb/tb_mdio_mgmt.sv
`timescale 1ns/1ps
module tb_mdio_mgmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, ctl_enable = 1'b0;
    logic [1:0]  ctl_div_sel = 2'd0;
    logic        frm_we = 1'b0;
    logic [31:0] frm_wdata = '0;
    logic [31:0] frm_rdata;
    logic        idle, mdc, mdio_in, mdio_out, mdio_oe;

    always #4 clk = ~clk;

    mdio_mgmt dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
        .ctl_div_sel(ctl_div_sel), .frm_we(frm_we), .frm_wdata(frm_wdata),
        .frm_rdata(frm_rdata), .idle(idle), .mdc(mdc), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    // behavioural reference
    bit          m_en = 0, m_busy = 0, m_read = 0;
    int          m_sel = 0, m_n = 8, m_t = 0;
    logic [31:0] m_frame = '0, m_word = '0;
    logic [15:0] phy_data = 16'h0000;

    initial mdio_in = 1'b1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst_n) begin
            if (m_busy) begin
                m_t++;
                if (m_t == 64 * m_n) begin
                    m_busy = 0;
                    if (m_read) m_frame[15:0] = phy_data;
                end
            end else if (frm_we && m_en) begin
                m_busy = 1; m_t = 0; m_frame = frm_wdata; m_word = frm_wdata;
                m_n = 8 << m_sel; m_read = (frm_wdata[29:28] == 2'b10);
            end
            if (ctl_we) begin m_en = ctl_enable; m_sel = ctl_div_sel; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int b;
            bit e_mdc, e_oe, e_out;
            b     = m_busy ? m_t / m_n : 0;
            e_mdc = m_busy && ((m_t % m_n) >= m_n / 2);
            e_oe  = m_busy && !(m_read && b >= 46);
            e_out = (b < 32) ? 1'b1 : m_word[63 - b];
            check(idle == !m_busy, "R3 idle", 32'(idle), 32'(!m_busy));
            check(mdc == e_mdc, "R4/R10 mdc", 32'(mdc), 32'(e_mdc));
            check(mdio_oe == e_oe, "R7 oe", 32'(mdio_oe), 32'(e_oe));
            if (e_oe) check(mdio_out == e_out, "R5/R6 data out", 32'(mdio_out), 32'(e_out));
            check(frm_rdata == m_frame, "R8 frame reg", frm_rdata, m_frame);
            mdio_in = (m_busy && m_read && b >= 48) ? phy_data[63 - b] : 1'b1;
        end
    end

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] dat);
        return {2'b01, op, phy, rg, (op == 2'b01) ? 2'b10 : 2'b00, dat};
    endfunction

    task automatic wr_ctl(input bit en, input logic [1:0] sel);
        @(negedge clk); ctl_we = 1'b1; ctl_enable = en; ctl_div_sel = sel;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_frame(input logic [31:0] w);
        @(negedge clk); frm_we = 1'b1; frm_wdata = w;
        @(negedge clk); frm_we = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!idle);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        if (cycles >= 0) begin
            wait (cycles > 100000);
            if (!finished) begin
                total++; bad++;
                $display("FAIL watchdog act=%0d exp=0", cycles);
                finished = 1;
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] w;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(idle == 1'b1, "R1 idle", 32'(idle), 1);
        check(mdc == 1'b0, "R1 mdc", 32'(mdc), 0);
        check(mdio_oe == 1'b0, "R1 oe", 32'(mdio_oe), 0);
        check(frm_rdata == 32'h0, "R1 frame", frm_rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: disabled port ignores a frame
        wr_frame(mk(2'b01, 5'd3, 5'd1, 16'hBEEF));
        repeat (3) @(negedge clk);
        check(idle == 1'b1, "R2 idle", 32'(idle), 1);
        check(frm_rdata == 32'h0, "R2 frame", frm_rdata, 0);

        // R3 / R9: write at ratio 8, second write while busy is ignored
        wr_ctl(1'b1, 2'd0);
        w = mk(2'b01, 5'd5, 5'd4, 16'hA5C3);
        wr_frame(w);
        check(idle == 1'b0, "R3 busy", 32'(idle), 0);
        repeat (20) @(negedge clk);
        wr_frame(mk(2'b10, 5'd9, 5'd9, 16'h1111));
        wait_idle();
        check(frm_rdata == w, "R9 frame kept", frm_rdata, w);

        // R8: read at ratio 16
        wr_ctl(1'b1, 2'd1);
        phy_data = 16'h1234;
        w = mk(2'b10, 5'd31, 5'd2, 16'h0000);
        wr_frame(w);
        wait_idle();
        check(frm_rdata == {w[31:16], 16'h1234}, "R8 read data", frm_rdata, {w[31:16], 16'h1234});

        // R10: read at ratio 32, divider changed mid-frame
        wr_ctl(1'b1, 2'd2);
        phy_data = 16'hF00D;
        wr_frame(mk(2'b10, 5'd1, 5'd31, 16'hFFFF));
        repeat (100) @(negedge clk);
        wr_ctl(1'b1, 2'd0);
        wait_idle();
        check(frm_rdata[15:0] == 16'hF00D, "R10 read after sel change", 32'(frm_rdata[15:0]), 32'hF00D);

        // R4 / R5: write at ratio 64
        wr_ctl(1'b1, 2'd3);
        wr_frame(mk(2'b01, 5'd16, 5'd0, 16'h8001));
        wait_idle();

        // R8: alternate read pattern at ratio 8
        wr_ctl(1'b1, 2'd0);
        phy_data = 16'h5AA5;
        w = mk(2'b10, 5'd0, 5'd17, 16'hCCCC);
        wr_frame(w);
        wait_idle();
        check(frm_rdata == {w[31:16], 16'h5AA5}, "R8 read pattern", frm_rdata, {w[31:16], 16'h5AA5});

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule